// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs a scatter-gather list that lives in memory as a chain of 16-byte descriptors. Each descriptor names one buffer. It gives the buffer's address, its length in 8-byte units, a direction bit, an ordering bit and a 4-bit transfer mode. It also holds a pointer to the following descriptor. After a start pulse with the address of the first descriptor, the walker reads that descriptor one 32-bit word at a time through a simple read port. It checks the descriptor and then raises one transfer request to a data mover. The request carries the buffer address, the byte count and the per-descriptor attributes. When the data mover acknowledges completion, the walker either stops, because the descriptor carried the end mark, or fetches the linked descriptor.

A walk ends in one of two ways. The first is a one-cycle done pulse. The second is a one-cycle error pulse with a code that tells a misaligned descriptor pointer, a misaligned buffer address and a zero length apart. The data movement itself and any buffering belong to the data mover and are not part of this block.

Top module: `prd_walker`

## Requirements
- R1: After reset, busy, rd_req, xfer_req, done and error are all low.
- R2: An accepted start makes the walker read the descriptor's four words at pointer, pointer+4, pointer+8 and pointer+12, in that order. Each rd_req is a one-cycle pulse, and the next pulse comes only after the previous word has been returned on rd_valid.
- R3: A descriptor is four little-endian words: buffer address, length, control, next pointer. For each valid descriptor, xfer_req carries:
  - xfer_addr equal to word 0;
  - xfer_bytes equal to word 1 times 8;
  - xfer_to_dev equal to control bit 5 (1 means memory to device);
  - xfer_ordered equal to control bit 4;
  - xfer_mode equal to control bits 11:8 (bits 15:12 are ignored).

  These fields stay stable until xfer_ack.
- R4: Control bit 7 marks the last descriptor. After xfer_ack on a descriptor without that mark, the next fetch starts at word 3. After the marked descriptor, word 3 is never followed.
- R5: No descriptor read is issued while xfer_req is high. The next fetch begins only after the current request is acknowledged.
- R6: done pulses for exactly one cycle, in the cycle right after the cycle in which xfer_ack completes the last descriptor. done and error never come together.
- R7: A start pointer whose low 3 bits are not zero gives an error pulse in the next cycle with err_code 1, and no read is issued.
- R8: A next pointer whose low 3 bits are not zero ends the walk after the current transfer is acknowledged, with err_code 1 and no further read.
- R9: A buffer address whose low 3 bits are not zero gives err_code 2 and no transfer request. This check takes priority over the zero-length check.
- R10: A length word of zero gives err_code 3 and no transfer request.
- R11: A start pulse while busy is high is ignored, and the walk in progress reads and transfers exactly as it would without the pulse.
- R12: A start pulse in the same cycle as done is accepted and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a walk (taken only when idle) |
| start_ptr | input | 32 | Address of the first descriptor |
| rd_req | output | 1 | One-cycle descriptor word read request |
| rd_addr | output | 32 | Byte address of the word being read |
| rd_valid | input | 1 | Read data returned (at least one cycle after rd_req) |
| rd_data | input | 32 | Returned word |
| xfer_req | output | 1 | Transfer request, held until xfer_ack |
| xfer_addr | output | 32 | Buffer address |
| xfer_bytes | output | 35 | Byte count (length units times 8) |
| xfer_to_dev | output | 1 | 1 means memory to device |
| xfer_ordered | output | 1 | Ordering attribute from the descriptor |
| xfer_mode | output | 4 | Transfer mode from the descriptor |
| xfer_ack | input | 1 | Transfer complete |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: chain completed |
| error | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 2 | 0 none, 1 pointer misaligned, 2 buffer misaligned, 3 zero length |

## Verification
The two functions that can share a cycle are the completion report of one walk and the acceptance of the next start. The bench waits for the done pulse and raises start in that same cycle, before the next clock edge. It then judges the result by the second chain's reads and transfer arriving at the ports. A second overlap, start arriving while a transfer is pending, is provoked mid-walk, and the bench checks that the read and transfer logs match the chain exactly.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    localparam int PTR_W      = 32;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 32;
    localparam int UNIT_SHIFT = 3;
    localparam int BYTES_W    = LEN_W + UNIT_SHIFT;
    localparam int ALIGN_BITS = 3;
    localparam int MODE_W     = 4;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // word positions inside one descriptor
    localparam int W_BUF  = 0;
    localparam int W_LEN  = 1;
    localparam int W_CTL  = 2;
    localparam int W_NEXT = 3;

    // control word layout
    localparam int FLAG_LSB   = 0;
    localparam int MODE_LSB   = 8;
    localparam int FLG_ORDER  = 4;
    localparam int FLG_TO_DEV = 5;
    localparam int FLG_LAST   = 7;

    typedef enum logic [1:0] {
        WERR_NONE      = 2'd0,
        WERR_PTR_ALIGN = 2'd1,
        WERR_BUF_ALIGN = 2'd2,
        WERR_ZERO_LEN  = 2'd3
    } walk_err_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_XFER
    } seq_state_e;

    typedef struct packed {
        logic [PTR_W-1:0]   buf_addr;
        logic [BYTES_W-1:0] bytes;
        logic               to_dev;
        logic               ordered;
        logic               last;
        logic [MODE_W-1:0]  mode;
        logic [PTR_W-1:0]   next_ptr;
    } prd_t;

    function automatic logic is_aligned(input logic [PTR_W-1:0] a);
        return a[ALIGN_BITS-1:0] == '0;
    endfunction

endpackage

// File: rtl/prd_fetch.sv
module prd_fetch
    import prd_walk_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              go,
    input  logic [PTR_W-1:0]                  go_ptr,
    output logic                              rd_req,
    output logic [PTR_W-1:0]                  rd_addr,
    input  logic                              rd_valid,
    input  logic [WORD_W-1:0]                 rd_data,
    output logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output logic                              words_valid
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);

    logic [PTR_W-1:0] base_q;
    logic [IDX_W-1:0] idx_q;
    logic             pending_q;
    logic             req_q;
    logic             full_q;
    logic             take;

    assign take = pending_q && rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            idx_q     <= '0;
            pending_q <= 1'b0;
            req_q     <= 1'b0;
            full_q    <= 1'b0;
            words     <= '0;
        end else begin
            req_q  <= 1'b0;
            full_q <= 1'b0;
            if (go) begin
                base_q    <= go_ptr;
                idx_q     <= '0;
                pending_q <= 1'b1;
                req_q     <= 1'b1;
            end else if (take) begin
                for (int w = 0; w < DESC_WORDS; w++) begin
                    if (idx_q == IDX_W'(w)) words[w] <= rd_data;
                end
                if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
                    pending_q <= 1'b0;
                    full_q    <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                    req_q <= 1'b1;
                end
            end
        end
    end

    assign rd_req      = req_q;
    assign rd_addr     = base_q + (PTR_W'(idx_q) << BYTE_SH);
    assign words_valid = full_q;

    // R2: one request outstanding, so requests never come back to back
    assert_single_req_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

endmodule

// File: rtl/prd_check.sv
module prd_check
    import prd_walk_pkg::*;
(
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output prd_t                              desc,
    output walk_err_e                         err
);
    logic [WORD_W-1:0] ctl_w;
    logic [7:0]        flag_b;
    logic [7:0]        mode_b;
    logic              unused_ctl_bits;

    assign ctl_w  = words[W_CTL];
    assign flag_b = ctl_w[FLAG_LSB +: 8];
    assign mode_b = ctl_w[MODE_LSB +: 8];
    assign unused_ctl_bits = ^{ctl_w[WORD_W-1:16], flag_b[6], flag_b[3:0], mode_b[7:MODE_W]};

    always_comb begin
        desc.buf_addr = words[W_BUF];
        desc.bytes    = {words[W_LEN][LEN_W-1:0], {UNIT_SHIFT{1'b0}}};
        desc.to_dev   = flag_b[FLG_TO_DEV];
        desc.ordered  = flag_b[FLG_ORDER];
        desc.last     = flag_b[FLG_LAST];
        desc.mode     = mode_b[MODE_W-1:0];
        desc.next_ptr = words[W_NEXT];

        if (!is_aligned(words[W_BUF]))
            err = WERR_BUF_ALIGN;
        else if (words[W_LEN] == '0)
            err = WERR_ZERO_LEN;
        else
            err = WERR_NONE;
    end

endmodule

// File: rtl/prd_seq.sv
module prd_seq
    import prd_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PTR_W-1:0]   start_ptr,
    output logic               fetch_go,
    output logic [PTR_W-1:0]   fetch_ptr,
    input  logic               desc_valid,
    input  prd_t               desc,
    input  walk_err_e          desc_err,
    output logic               xfer_req,
    output logic [PTR_W-1:0]   xfer_addr,
    output logic [BYTES_W-1:0] xfer_bytes,
    output logic               xfer_to_dev,
    output logic               xfer_ordered,
    output logic [MODE_W-1:0]  xfer_mode,
    input  logic               xfer_ack,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [1:0]         err_code
);
    seq_state_e state_q;
    prd_t       cur_q;
    logic       req_q;
    logic       done_q;
    logic       err_q;
    walk_err_e  code_q;

    always_comb begin
        fetch_go  = 1'b0;
        fetch_ptr = start_ptr;
        if (state_q == S_IDLE && start && is_aligned(start_ptr)) begin
            fetch_go = 1'b1;
        end else if (state_q == S_XFER && xfer_ack && !cur_q.last && is_aligned(cur_q.next_ptr)) begin
            fetch_go  = 1'b1;
            fetch_ptr = cur_q.next_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= WERR_NONE;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (is_aligned(start_ptr)) begin
                            code_q  <= WERR_NONE;
                            state_q <= S_FETCH;
                        end else begin
                            err_q  <= 1'b1;
                            code_q <= WERR_PTR_ALIGN;
                        end
                    end
                end
                S_FETCH: begin
                    if (desc_valid) begin
                        if (desc_err != WERR_NONE) begin
                            err_q   <= 1'b1;
                            code_q  <= desc_err;
                            state_q <= S_IDLE;
                        end else begin
                            cur_q   <= desc;
                            req_q   <= 1'b1;
                            state_q <= S_XFER;
                        end
                    end
                end
                S_XFER: begin
                    if (xfer_ack) begin
                        req_q <= 1'b0;
                        if (cur_q.last) begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else if (is_aligned(cur_q.next_ptr)) begin
                            state_q <= S_FETCH;
                        end else begin
                            err_q   <= 1'b1;
                            code_q  <= WERR_PTR_ALIGN;
                            state_q <= S_IDLE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign xfer_req     = req_q;
    assign xfer_addr    = cur_q.buf_addr;
    assign xfer_bytes   = cur_q.bytes;
    assign xfer_to_dev  = cur_q.to_dev;
    assign xfer_ordered = cur_q.ordered;
    assign xfer_mode    = cur_q.mode;
    assign busy         = state_q != S_IDLE;
    assign done         = done_q;
    assign error        = err_q;
    assign err_code     = code_q;

    // R3: request fields hold until acknowledged
    assert_fields_stable_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_ack |=> xfer_req && $stable(cur_q));

    // R6: completion follows an acknowledged request by one cycle
    assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(xfer_req && xfer_ack));

    // R7: misaligned start pointer is reported next cycle
    assert_bad_start_R7: assert property (@(posedge clk) disable iff (rst)
        state_q == S_IDLE && start && !is_aligned(start_ptr)
            |=> error && err_code == WERR_PTR_ALIGN && !busy);

    // R8: misaligned link pointer stops the walk after the ack
    assert_bad_link_R8: assert property (@(posedge clk) disable iff (rst)
        state_q == S_XFER && xfer_ack && !cur_q.last && !is_aligned(cur_q.next_ptr)
            |=> error && err_code == WERR_PTR_ALIGN && !busy);

    // R9: a rejected descriptor never raises a transfer request
    assert_no_xfer_on_reject_R9: assert property (@(posedge clk) disable iff (rst)
        state_q == S_FETCH && desc_valid && desc_err != WERR_NONE |=> error && !xfer_req);

endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        start_ptr,
    output logic               rd_req,
    output logic [31:0]        rd_addr,
    input  logic               rd_valid,
    input  logic [31:0]        rd_data,
    output logic               xfer_req,
    output logic [31:0]        xfer_addr,
    output logic [34:0]        xfer_bytes,
    output logic               xfer_to_dev,
    output logic               xfer_ordered,
    output logic [3:0]         xfer_mode,
    input  logic               xfer_ack,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [1:0]         err_code
);
    logic                              fetch_go;
    logic [PTR_W-1:0]                  fetch_ptr;
    logic [DESC_WORDS-1:0][WORD_W-1:0] words;
    logic                              words_valid;
    prd_t                              desc;
    walk_err_e                         desc_err;

    prd_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (fetch_go),
        .go_ptr     (fetch_ptr),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .words      (words),
        .words_valid(words_valid)
    );

    prd_check u_check (
        .words(words),
        .desc (desc),
        .err  (desc_err)
    );

    prd_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_ptr   (start_ptr),
        .fetch_go    (fetch_go),
        .fetch_ptr   (fetch_ptr),
        .desc_valid  (words_valid),
        .desc        (desc),
        .desc_err    (desc_err),
        .xfer_req    (xfer_req),
        .xfer_addr   (xfer_addr),
        .xfer_bytes  (xfer_bytes),
        .xfer_to_dev (xfer_to_dev),
        .xfer_ordered(xfer_ordered),
        .xfer_mode   (xfer_mode),
        .xfer_ack    (xfer_ack),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .err_code    (err_code)
    );

    // R5: descriptor reads and a pending transfer never overlap
    assert_no_fetch_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !rd_req);

endmodule

// File: tb/prd_walker_tb.sv
module prd_walker_tb;

    typedef struct packed {
        logic [3:0]  ndesc;
        logic [15:0] len_base;
        logic        wr;
        logic [3:0]  mlat;
        logic [3:0]  alat;
        logic [3:0]  mode;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 16'h0001, 1'b0, 4'd1, 4'd0, 4'h3},
        '{4'd3, 16'h0010, 1'b1, 4'd2, 4'd3, 4'hC},
        '{4'd4, 16'h0200, 1'b0, 4'd4, 4'd1, 4'h5},
        '{4'd2, 16'hFFF0, 1'b1, 4'd1, 4'd5, 4'hF},
        '{4'd4, 16'h0007, 1'b1, 4'd3, 4'd0, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [34:0] xfer_bytes;
    logic        xfer_to_dev;
    logic        xfer_ordered;
    logic [3:0]  xfer_mode;
    logic        xfer_ack;
    logic        busy;
    logic        done;
    logic        error;
    logic [1:0]  err_code;

    always #5 clk = ~clk;

    prd_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
        .xfer_to_dev(xfer_to_dev), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
        .xfer_ack(xfer_ack), .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    logic [31:0] mem [0:255];
    int          mem_lat = 1;
    int          ack_lat = 0;
    int          mem_wait = 0;
    int          ack_cnt = 0;
    logic [31:0] mem_addr;

    logic [31:0] rd_log [0:63];
    logic [31:0] xa_log [0:15];
    logic [34:0] xb_log [0:15];
    logic        xw_log [0:15];
    logic        xo_log [0:15];
    logic [3:0]  xm_log [0:15];
    int          rd_n = 0;
    int          xf_n = 0;
    int          overlap_n = 0;
    time         ack_time = 0;
    time         end_time = 0;

    int checks = 0;
    int fails  = 0;

    // memory model: answers each request at least one cycle later
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (mem_wait > 0) begin
                mem_wait--;
                if (mem_wait == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[mem_addr[9:2]];
                end
            end else if (rd_req) begin
                mem_addr = rd_addr;
                mem_wait = mem_lat;
                if (rd_n < 64) rd_log[rd_n] = rd_addr;
                rd_n++;
                if (xfer_req) overlap_n++;
            end
        end
    end

    // data mover model: acknowledges after ack_lat waiting cycles
    initial begin
        xfer_ack = 1'b0;
        forever begin
            @(negedge clk);
            xfer_ack = 1'b0;
            if (xfer_req) begin
                if (ack_cnt >= ack_lat) begin
                    xfer_ack = 1'b1;
                    ack_cnt  = 0;
                    ack_time = $time;
                    if (xf_n < 16) begin
                        xa_log[xf_n] = xfer_addr;
                        xb_log[xf_n] = xfer_bytes;
                        xw_log[xf_n] = xfer_to_dev;
                        xo_log[xf_n] = xfer_ordered;
                        xm_log[xf_n] = xfer_mode;
                    end
                    xf_n++;
                end else begin
                    ack_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic clear_logs();
        rd_n = 0;
        xf_n = 0;
        overlap_n = 0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] buf_a, input logic [31:0] len,
                            input logic [7:0] flags, input logic [7:0] modeb, input logic [31:0] nxt);
        mem[a[9:2]]        = buf_a;
        mem[a[9:2] + 8'd1] = len;
        mem[a[9:2] + 8'd2] = {8'h00, 8'h77, modeb, flags};
        mem[a[9:2] + 8'd3] = nxt;
    endtask

    task automatic raise_start(input logic [31:0] ptr);
        @(negedge clk);
        start_ptr = ptr;
        start     = 1'b1;
    endtask

    // drops start after one cycle, then waits for done or error
    task automatic wait_end(output bit d, output bit e, output logic [1:0] c);
        d = 1'b0;
        e = 1'b0;
        c = 2'd0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done || error) begin
                d = done;
                e = error;
                c = err_code;
                end_time = $time;
                return;
            end
        end
        check(1'b0, "R6 walk timeout", 64'd0, 64'd1);
    endtask

    function automatic logic [31:0] daddr(input int n, input int i);
        return 32'h40 + 32'h50 * (n - 1 - i);
    endfunction

    initial begin
        bit          d;
        bit          e;
        logic [1:0]  c;
        vec_t        t;
        bit          lst;
        logic [31:0] base;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(!busy && !rd_req && !xfer_req && !done && !error, "R1 reset outputs",
              {59'd0, busy, rd_req, xfer_req, done, error}, 64'd0);

        // table-driven chains: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            t = VECS[v];
            clear_mem();
            clear_logs();
            mem_lat = int'(t.mlat);
            ack_lat = int'(t.alat);
            for (int i = 0; i < int'(t.ndesc); i++) begin
                lst = (i == int'(t.ndesc) - 1);
                put_desc(daddr(int'(t.ndesc), i),
                         32'h10000 * (i + 1) + 32'h8 * v,
                         32'(t.len_base) + 32'(i),
                         {lst, 1'b1, t.wr, i[0], 4'b0001},
                         {4'hA, t.mode},
                         lst ? 32'hDEADBEE5 : daddr(int'(t.ndesc), i + 1));
            end
            raise_start(daddr(int'(t.ndesc), 0));
            wait_end(d, e, c);
            check(d && !e, "R6 chain ends with done", {62'd0, d, e}, 64'd2);
            check(end_time - ack_time == 10, "R6 done one cycle after last ack",
                  64'(end_time - ack_time), 64'd10);
            @(negedge clk);
            check(!done, "R6 done is one cycle", 64'(done), 64'd0);
            check(xf_n == int'(t.ndesc), "R4 transfer count", 64'(xf_n), 64'(t.ndesc));
            check(rd_n == 4 * int'(t.ndesc), "R4 read count stops at last", 64'(rd_n), 64'(4 * t.ndesc));
            check(overlap_n == 0, "R5 read during transfer", 64'(overlap_n), 64'd0);
            for (int i = 0; i < int'(t.ndesc); i++) begin
                base = daddr(int'(t.ndesc), i);
                for (int k = 0; k < 4; k++)
                    check(rd_log[4*i+k] == base + 32'(4*k), "R2 read address order",
                          64'(rd_log[4*i+k]), 64'(base + 32'(4*k)));
                check(xa_log[i] == 32'h10000 * (i + 1) + 32'h8 * v, "R3 xfer_addr",
                      64'(xa_log[i]), 64'(32'h10000 * (i + 1) + 32'h8 * v));
                check(xb_log[i] == 35'((32'(t.len_base) + 32'(i)) * 8), "R3 xfer_bytes",
                      64'(xb_log[i]), 64'((32'(t.len_base) + 32'(i)) * 8));
                check(xw_log[i] == t.wr && xo_log[i] == i[0] && xm_log[i] == t.mode,
                      "R3 direction order mode",
                      {58'd0, xw_log[i], xo_log[i], xm_log[i]}, {58'd0, t.wr, i[0], t.mode});
            end
        end

        mem_lat = 1;
        ack_lat = 2;

        // R7: misaligned start pointer
        clear_mem();
        clear_logs();
        raise_start(32'h104);
        wait_end(d, e, c);
        check(e && !d && c == 2'd1, "R7 misaligned start", {61'd0, e, c}, {61'd0, 1'b1, 2'd1});
        check(rd_n == 0, "R7 no read issued", 64'(rd_n), 64'd0);

        // R8: misaligned link pointer
        clear_mem();
        clear_logs();
        put_desc(32'h40, 32'h5000, 32'd4, 8'h00, 8'h02, 32'h8C);
        raise_start(32'h40);
        wait_end(d, e, c);
        check(e && !d && c == 2'd1, "R8 misaligned link", {61'd0, e, c}, {61'd0, 1'b1, 2'd1});
        check(xf_n == 1 && rd_n == 4, "R8 one transfer then stop", {32'(xf_n), 32'(rd_n)}, {32'd1, 32'd4});

        // R9: misaligned buffer wins over zero length
        clear_mem();
        clear_logs();
        put_desc(32'h40, 32'h1004, 32'd0, 8'h80, 8'h00, 32'h0);
        raise_start(32'h40);
        wait_end(d, e, c);
        check(e && c == 2'd2, "R9 misaligned buffer code", {61'd0, e, c}, {61'd0, 1'b1, 2'd2});
        check(xf_n == 0, "R9 no transfer", 64'(xf_n), 64'd0);

        // R10: zero length
        clear_mem();
        clear_logs();
        put_desc(32'h40, 32'h1000, 32'd0, 8'h80, 8'h00, 32'h0);
        raise_start(32'h40);
        wait_end(d, e, c);
        check(e && c == 2'd3, "R10 zero length code", {61'd0, e, c}, {61'd0, 1'b1, 2'd3});
        check(xf_n == 0, "R10 no transfer", 64'(xf_n), 64'd0);

        // R11: start while busy is ignored
        clear_mem();
        clear_logs();
        ack_lat = 15;
        put_desc(32'h40, 32'h6000, 32'd2, 8'h00, 8'h01, 32'h80);
        put_desc(32'h80, 32'h7000, 32'd3, 8'h80, 8'h01, 32'h0);
        put_desc(32'h300, 32'h9000, 32'd9, 8'h80, 8'h01, 32'h0);
        raise_start(32'h40);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R11 walk in progress", 64'(busy), 64'd1);
        start_ptr = 32'h300;
        start     = 1'b1;
        wait_end(d, e, c);
        check(d && !e, "R11 walk completes", {62'd0, d, e}, 64'd2);
        check(rd_n == 8 && rd_log[4] == 32'h80, "R11 reads unchanged", {32'(rd_n), rd_log[4]}, {32'd8, 32'h80});
        check(xf_n == 2 && xa_log[1] == 32'h7000, "R11 transfers unchanged", {32'(xf_n), xa_log[1]}, {32'd2, 32'h7000});

        // R12: start in the done cycle
        clear_mem();
        clear_logs();
        ack_lat = 1;
        put_desc(32'h40, 32'h2000, 32'd2, 8'h80, 8'h04, 32'h0);
        put_desc(32'h80, 32'h3000, 32'd3, 8'hA0, 8'h06, 32'h0);
        raise_start(32'h40);
        wait_end(d, e, c);
        check(d, "R12 first walk done", 64'(d), 64'd1);
        start_ptr = 32'h80;
        start     = 1'b1;
        wait_end(d, e, c);
        check(d && !e, "R12 second walk done", {62'd0, d, e}, 64'd2);
        check(xf_n == 2 && xa_log[1] == 32'h3000 && rd_log[4] == 32'h80, "R12 back-to-back walk",
              {16'(xf_n), xa_log[1][15:0], rd_log[4]}, {16'd2, 16'h3000, 32'h80});
        check(xw_log[1] == 1'b1 && xb_log[1] == 35'd24, "R12 second request fields",
              {28'd0, xw_log[1], xb_log[1]}, {28'd0, 1'b1, 35'd24});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule